// File: doc/BRIEF.md
# Split-Word Interrupt Register Front End

This block is the software-facing register bank of a 51-source interrupt controller. The capture logic beside it turns the raw request lines into a pending vector. This block takes that vector in. It holds the per-source enable, the fast-path routing select and the polarity configuration, and it combines them into two request lines toward the processor. The normal request line is `irq_o` and the fast request line is `fiq_o`.

Each 51-bit quantity is seen on a 32-bit bus as two words 4 bytes apart. The low word carries sources 31..0. The high word carries sources 50..32 in its bits 18:0. The bank starts at byte offset 0x80, and the bus gives the word address (byte offset bits 7:2). Enable has separate set and clear addresses, so software never needs a read-modify-write. Edge-pending bits are cleared by driving a one-cycle clear vector back to the capture logic. The sense and dual-edge configuration are fixed by parameters and are visible read-only.

Top module: `vic_regif`

## Requirements
- R1: While reset is asserted, and after its release, enable and select are all zero, polarity equals its reset value (51'h5F07FFF8FFFF), read data is zero and both request outputs are low.
- R2: Byte offsets 0x80..0xE7 are decoded in 8-byte slots: IRQ status 0x80, FIQ status 0x88, raw 0x90, select 0x98, enable-set 0xA0, enable-clear 0xA8, soft-interrupt 0xB0, soft-clear 0xB8, sense 0xC0, dual-edge 0xC8, polarity 0xD0, edge-clear 0xD8, edge status 0xE0. Offset bit 2 selects the high word, which maps sources 50..32 to bits 18:0 and reads zero in bits 31:19.
- R3: A write to enable-set ORs the placed data into enable. A write to enable-clear removes the placed data bits from enable. Enable reads back at the enable-set address.
- R4: A select write replaces only the addressed half and leaves the other half unchanged.
- R5: IRQ status reads pending AND enable AND NOT select. FIQ status reads pending AND enable AND select. `irq_o` and `fiq_o` are the OR-reductions of those vectors and follow a register write on the next cycle.
- R6: Edge status reads pending AND NOT sense. A write to the edge-clear address drives `eclr_o` = placed data AND NOT sense during that write cycle. `eclr_o` is zero in every other cycle.
- R7: Polarity changes only on a high-word write and only in sources 50..47 (high-word bits 18:15). A low-word polarity write leaves it unchanged. `polarity_o` shows the register.
- R8: Reads of enable-clear, soft-clear, edge-clear, soft-interrupt, offsets below 0x80 and offsets 0xE8 and up return zero. Writes to status, raw, sense, dual-edge, soft-interrupt, soft-clear, unmapped and sub-0x80 offsets change no state.
- R9: Read data appears one cycle after the read is presented and holds until the next read.
- R10: Sense reads 51'h1F07FFF8FFFF and dual-edge reads 51'h0F800070000 (1 = level-sensed, 1 = both edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Transfer valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address (byte offset bits 7:2) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pend_i | input | 51 | Pending vector from capture logic |
| polarity_o | output | 51 | Polarity configuration to capture logic |
| eclr_o | output | 51 | Edge-pending clear strobe to capture logic |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is the mix of half-word placement with masked state. Examples are a high-word select write that must keep the low half, and a high-word polarity write where only four of nineteen bits may move. The same holds for edge-clear, which must drop level-sensed bits of a random pattern. Random transfers over both halves of every slot are therefore mixed with random pending vectors, and each read is compared against a bench model of the three registers. Directed writes of all-ones to the high words, to the read-only addresses and to the low polarity word cover the masked corners explicitly.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Register slots in address order; the order follows the bus map.
  typedef enum logic [3:0] {
    RG_NONE,
    RG_IRQST,
    RG_FIQST,
    RG_RAW,
    RG_SELECT,
    RG_ENSET,
    RG_ENCLR,
    RG_SWI,
    RG_SWICLR,
    RG_SENSE,
    RG_DUAL,
    RG_POL,
    RG_ECLR,
    RG_ESTAT
  } reg_id_e;

  localparam int unsigned NUM_SLOTS = 13;

endpackage

// File: rtl/vic_rstsync.sv
module vic_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/vic_regdec.sv
module vic_regdec
  import vic_pkg::*;
#(
  parameter int unsigned AW        = 6,
  parameter int unsigned BASE_BYTE = 128
) (
  input  logic [AW-1:0] waddr,
  output reg_id_e       rid,
  output logic          hi
);

  localparam int unsigned SW        = AW - 1;
  localparam int unsigned BASE_SLOT = BASE_BYTE / 8;

  logic [SW-1:0] slot;
  logic [SW-1:0] idx;

  assign slot = waddr[AW-1:1];
  assign idx  = slot - SW'(BASE_SLOT);

  always_comb begin
    hi  = waddr[0];
    rid = RG_NONE;
    if ((int'(slot) >= BASE_SLOT) && (int'(slot) < BASE_SLOT + NUM_SLOTS)) begin
      case (int'(idx))
        0:       rid = RG_IRQST;
        1:       rid = RG_FIQST;
        2:       rid = RG_RAW;
        3:       rid = RG_SELECT;
        4:       rid = RG_ENSET;
        5:       rid = RG_ENCLR;
        6:       rid = RG_SWI;
        7:       rid = RG_SWICLR;
        8:       rid = RG_SENSE;
        9:       rid = RG_DUAL;
        10:      rid = RG_POL;
        11:      rid = RG_ECLR;
        12:      rid = RG_ESTAT;
        default: rid = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int unsigned      NSRC      = 51,
  parameter int unsigned      DW        = 32,
  parameter logic [NSRC-1:0]  SENSE_CFG = 51'h1F07FFF8FFFF,
  parameter logic [NSRC-1:0]  POL_RST   = 51'h5F07FFF8FFFF,
  parameter logic [NSRC-1:0]  POL_WMASK = 51'h7800000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen,
  input  reg_id_e         rid,
  input  logic            hi,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] pol_q,
  output logic [NSRC-1:0] eclr_o
);

  localparam int unsigned HB = NSRC - DW;

  logic [NSRC-1:0] wvec;
  logic [NSRC-1:0] hmask;
  logic [NSRC-1:0] en_d;
  logic [NSRC-1:0] sel_d;
  logic [NSRC-1:0] pol_d;
  logic            en_ce;
  logic            sel_ce;
  logic            pol_ce;

  // Place the bus word onto the addressed half of the source vector.
  always_comb begin
    wvec  = '0;
    hmask = '0;
    if (hi) begin
      wvec[NSRC-1:DW]  = wdata[HB-1:0];
      hmask[NSRC-1:DW] = '1;
    end else begin
      wvec[DW-1:0]  = wdata;
      hmask[DW-1:0] = '1;
    end
  end

  // Next-state logic.
  always_comb begin
    en_ce  = wen && ((rid == RG_ENSET) || (rid == RG_ENCLR));
    en_d   = (rid == RG_ENSET) ? (en_q | wvec) : (en_q & ~wvec);
    sel_ce = wen && (rid == RG_SELECT);
    sel_d  = (sel_q & ~hmask) | wvec;
    pol_ce = wen && (rid == RG_POL) && hi;
    pol_d  = (pol_q & ~POL_WMASK) | (wvec & POL_WMASK);
    eclr_o = (wen && (rid == RG_ECLR)) ? (wvec & ~SENSE_CFG) : '0;
  end

  // State registers with explicit clock enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
      pol_q <= POL_RST;
    end else begin
      if (en_ce) begin
        en_q <= en_d;
      end
      if (sel_ce) begin
        sel_q <= sel_d;
      end
      if (pol_ce) begin
        pol_q <= pol_d;
      end
    end
  end

endmodule

// File: rtl/vic_regif.sv
module vic_regif
  import vic_pkg::*;
#(
  parameter int unsigned     NSRC      = 51,
  parameter int unsigned     DW        = 32,
  parameter int unsigned     AW        = 6,
  parameter int unsigned     BASE_BYTE = 128,
  parameter logic [NSRC-1:0] SENSE_CFG = 51'h1F07FFF8FFFF,
  parameter logic [NSRC-1:0] DUAL_CFG  = 51'h0F800070000,
  parameter logic [NSRC-1:0] POL_RST   = 51'h5F07FFF8FFFF,
  parameter logic [NSRC-1:0] POL_WMASK = 51'h7800000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] polarity_o,
  output logic [NSRC-1:0] eclr_o,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam int unsigned HB = NSRC - DW;

  logic            rst_sync_n;
  reg_id_e         rid;
  logic            hi;
  logic            wen;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] sel_q;
  logic [NSRC-1:0] pol_q;
  logic [NSRC-1:0] rval;
  logic [NSRC-1:0] act_vec;
  logic [DW-1:0]   rdata_d;
  logic [DW-1:0]   rdata_q;
  logic            rd_ce;

  vic_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  vic_regdec #(.AW(AW), .BASE_BYTE(BASE_BYTE)) u_dec (
    .waddr (bus_addr_i),
    .rid   (rid),
    .hi    (hi)
  );

  assign wen = bus_sel_i && bus_wr_i;

  vic_regfile #(
    .NSRC      (NSRC),
    .DW        (DW),
    .SENSE_CFG (SENSE_CFG),
    .POL_RST   (POL_RST),
    .POL_WMASK (POL_WMASK)
  ) u_rf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wen    (wen),
    .rid    (rid),
    .hi     (hi),
    .wdata  (bus_wdata_i),
    .en_q   (en_q),
    .sel_q  (sel_q),
    .pol_q  (pol_q),
    .eclr_o (eclr_o)
  );

  assign act_vec = pend_i & en_q;
  assign irq_o   = |(act_vec & ~sel_q);
  assign fiq_o   = |(act_vec & sel_q);

  // Read selection; write-only and unmapped slots fall to zero.
  always_comb begin
    case (rid)
      RG_IRQST:  rval = act_vec & ~sel_q;
      RG_FIQST:  rval = act_vec & sel_q;
      RG_RAW:    rval = pend_i;
      RG_SELECT: rval = sel_q;
      RG_ENSET:  rval = en_q;
      RG_SENSE:  rval = SENSE_CFG;
      RG_DUAL:   rval = DUAL_CFG;
      RG_POL:    rval = pol_q;
      RG_ESTAT:  rval = pend_i & ~SENSE_CFG;
      default:   rval = '0;
    endcase
    rd_ce   = bus_sel_i && !bus_wr_i;
    rdata_d = hi ? {{(DW-HB){1'b0}}, rval[NSRC-1:DW]} : rval[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rd_ce) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign polarity_o  = pol_q;

endmodule

// File: rtl/vic_regif_chk.sv
module vic_regif_chk #(
  parameter int unsigned NSRC = 51,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel_i,
  input logic            bus_wr_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [DW-1:0]   bus_rdata_o,
  input logic [NSRC-1:0] eclr_o,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] sel_q,
  input logic [NSRC-1:0] pol_q
);

  localparam int unsigned HB = NSRC - DW;
  localparam logic [AW-1:0] WA_SEL_LO = AW'(6'h26);
  localparam logic [AW-1:0] WA_ENS_LO = AW'(6'h28);
  localparam logic [AW-1:0] WA_ENC_LO = AW'(6'h2A);
  localparam logic [AW-1:0] WA_POL_LO = AW'(6'h34);
  localparam logic [AW-1:0] WA_BASE   = AW'(6'h20);

  logic wr_cyc;
  logic rd_cyc;
  assign wr_cyc = bus_sel_i && bus_wr_i;
  assign rd_cyc = bus_sel_i && !bus_wr_i;

  AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && bus_addr_i[0] && (bus_addr_i >= WA_BASE)) |=> (bus_rdata_o[DW-1:HB] == '0)); // R2

  AST_EN_SET_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && (bus_addr_i == WA_ENS_LO)) |=> ((en_q[DW-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R3

  AST_EN_CLR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && (bus_addr_i == WA_ENC_LO)) |=> ((en_q[DW-1:0] & $past(bus_wdata_i)) == '0)); // R3

  AST_SEL_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && (bus_addr_i == WA_SEL_LO)) |=> $stable(sel_q[NSRC-1:DW])); // R4

  AST_QUIET_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_o && !fiq_o)); // R5

  AST_ECLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |-> (eclr_o == '0)); // R6

  AST_POL_LO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && (bus_addr_i == WA_POL_LO)) |=> $stable(pol_q)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |=> $stable(bus_rdata_o)); // R9

endmodule

bind vic_regif vic_regif_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .eclr_o      (eclr_o),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .en_q        (en_q),
  .sel_q       (sel_q),
  .pol_q       (pol_q)
);

// File: tb/sim_vic_regif.sv
`timescale 1ns/1ps
module sim_vic_regif;

  localparam logic [50:0] SENSE = 51'h1F07FFF8FFFF;
  localparam logic [50:0] DUAL  = 51'h0F800070000;
  localparam logic [50:0] PRST  = 51'h5F07FFF8FFFF;
  localparam logic [50:0] PWM   = 51'h7800000000000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel_i;
  logic        bus_wr_i;
  logic [5:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [50:0] pend_i;
  logic [50:0] polarity_o;
  logic [50:0] eclr_o;
  logic        irq_o;
  logic        fiq_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [50:0] m_en;
  logic [50:0] m_sel;
  logic [50:0] m_pol;

  always #5 clk = ~clk;

  vic_regif u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_i      (pend_i),
    .polarity_o  (polarity_o),
    .eclr_o      (eclr_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [50:0] place(input logic [7:0] a, input logic [31:0] d);
    place = a[2] ? {d[18:0], 32'h0} : {19'h0, d};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [50:0] v;
    v = '0;
    if (a >= 8'h80) begin
      case (a & 8'hF8)
        8'h80: v = pend_i & m_en & ~m_sel;
        8'h88: v = pend_i & m_en & m_sel;
        8'h90: v = pend_i;
        8'h98: v = m_sel;
        8'hA0: v = m_en;
        8'hC0: v = SENSE;
        8'hC8: v = DUAL;
        8'hD0: v = m_pol;
        8'hE0: v = pend_i & ~SENSE;
        default: v = '0;
      endcase
    end
    model_read = a[2] ? {13'h0, v[50:32]} : v[31:0];
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    logic [50:0] w;
    w = place(a, d);
    if (a >= 8'h80) begin
      case (a & 8'hF8)
        8'h98: m_sel = a[2] ? {d[18:0], m_sel[31:0]} : {m_sel[50:32], d};
        8'hA0: m_en = m_en | w;
        8'hA8: m_en = m_en & ~w;
        8'hD0: if (a[2]) m_pol = (m_pol & ~PWM) | (w & PWM);
        default: ;
      endcase
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    logic [50:0] exp_clr;
    bus_sel_i   = 1'b1;
    bus_wr_i    = 1'b1;
    bus_addr_i  = a[7:2];
    bus_wdata_i = d;
    exp_clr = ((a & 8'hF8) == 8'hD8) ? (place(a, d) & ~SENSE) : '0;
    #1;
    check(eclr_o == exp_clr, "R6 edge-clear strobe", 64'(eclr_o), 64'(exp_clr));
    @(negedge clk);
    bus_sel_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    logic [31:0] exp;
    bus_sel_i  = 1'b1;
    bus_wr_i   = 1'b0;
    bus_addr_i = a[7:2];
    exp = model_read(a);
    @(negedge clk);
    bus_sel_i = 1'b0;
    check(bus_rdata_o == exp, tag, 64'(bus_rdata_o), 64'(exp));
  endtask

  task automatic check_lines(input string tag);
    logic ei;
    logic ef;
    ei = |(pend_i & m_en & ~m_sel);
    ef = |(pend_i & m_en & m_sel);
    check((irq_o == ei) && (fiq_o == ef), tag, {62'h0, irq_o, fiq_o}, {62'h0, ei, ef});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    bus_sel_i = 1'b0;
    bus_wr_i = 1'b0;
    bus_addr_i = '0;
    bus_wdata_i = '0;
    pend_i = '0;
    m_en = '0;
    m_sel = '0;
    m_pol = PRST;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(bus_rdata_o == 32'h0, "R1 rdata in reset", 64'(bus_rdata_o), 64'h0);
    check(polarity_o == PRST, "R1 polarity reset", 64'(polarity_o), 64'(PRST));
    pend_i = '1;
    #1;
    check(!irq_o && !fiq_o, "R1 lines low with enable clear", {62'h0, irq_o, fiq_o}, 64'h0);
    pend_i = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(8'hA0, "R1 enable zero after reset");
    bus_read(8'h9C, "R1 select high zero after reset");

    // R10: fixed configuration
    bus_read(8'hC0, "R10 sense low");
    bus_read(8'hC4, "R10 sense high");
    bus_read(8'hC8, "R10 dual low");
    bus_read(8'hCC, "R10 dual high");

    // R3 and R2: set/clear, high-word masking
    bus_write(8'hA0, 32'h0000_00FF);
    bus_read(8'hA0, "R3 enable set low");
    bus_write(8'hA4, 32'hFFFF_FFFF);
    bus_read(8'hA4, "R2 high word masked to 19 bits");
    bus_write(8'hA8, 32'h0000_000F);
    bus_read(8'hA0, "R3 enable clear low");
    bus_write(8'hAC, 32'h0004_0001);
    bus_read(8'hA4, "R3 enable clear high");

    // R4: half-word select replacement
    bus_write(8'h98, 32'hAAAA_5555);
    bus_write(8'h9C, 32'hFFF1_2345);
    bus_read(8'h98, "R4 select low");
    bus_read(8'h9C, "R4 select high");
    bus_write(8'h98, 32'h0000_0000);
    bus_read(8'h9C, "R4 high kept after low write");
    bus_write(8'h98, 32'h0000_0010);

    // R5: routing to lines and status words
    pend_i = 51'h0000_0000_0030;
    #1;
    check_lines("R5 mixed irq/fiq");
    bus_read(8'h80, "R5 irq status");
    bus_read(8'h88, "R5 fiq status");
    pend_i = 51'h0000_0000_0010;
    #1;
    check_lines("R5 fiq only");
    bus_write(8'hA8, 32'h0000_0010);
    check_lines("R5 line drops after enable clear");
    pend_i = {1'b1, 50'h0};
    bus_write(8'hA4, 32'h0004_0000);
    check_lines("R5 top source on irq");
    bus_read(8'h84, "R5 irq status high word");

    // R6: edge status and clear strobe
    pend_i = 51'h7_FFFF_FFFF_FFFF;
    bus_read(8'hE0, "R6 edge status low");
    bus_read(8'hE4, "R6 edge status high");
    bus_write(8'hD8, 32'hFFFF_FFFF);
    bus_write(8'hDC, 32'hFFFF_FFFF);
    bus_write(8'hA0, 32'hFFFF_FFFF);

    // R7: polarity
    bus_write(8'hD0, 32'h0000_0000);
    bus_read(8'hD0, "R7 low write ignored");
    bus_write(8'hD4, 32'h0000_0000);
    bus_read(8'hD4, "R7 high write masked");
    check(polarity_o == m_pol, "R7 polarity output", 64'(polarity_o), 64'(m_pol));
    bus_write(8'hD4, 32'hFFFF_FFFF);
    check(polarity_o == m_pol, "R7 polarity set bits 50..47", 64'(polarity_o), 64'(m_pol));

    // R8: write-only, unmapped and legacy reads; ignored writes
    bus_read(8'hA8, "R8 enable-clear reads zero");
    bus_read(8'hB8, "R8 soft-clear reads zero");
    bus_read(8'hDC, "R8 edge-clear reads zero");
    bus_read(8'hB0, "R8 soft-interrupt reads zero");
    bus_read(8'hE8, "R8 unmapped reads zero");
    bus_read(8'h10, "R8 legacy range reads zero");
    bus_write(8'hB0, 32'hFFFF_FFFF);
    bus_write(8'hC0, 32'h0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h90, 32'h0);
    bus_read(8'hA0, "R8 enable untouched by ignored writes");
    bus_read(8'hC0, "R8 sense untouched");
    bus_read(8'hB0, "R8 soft-interrupt still zero");

    // R9: latency and hold
    bus_read(8'hC4, "R9 setup read");
    keep = bus_rdata_o;
    bus_sel_i = 1'b1;
    bus_wr_i = 1'b0;
    bus_addr_i = 6'h30;
    #1;
    check(bus_rdata_o == keep, "R9 no change before edge", 64'(bus_rdata_o), 64'(keep));
    @(negedge clk);
    bus_sel_i = 1'b0;
    check(bus_rdata_o == model_read(8'hC0), "R9 new data after one edge", 64'(bus_rdata_o), 64'(model_read(8'hC0)));
    keep = bus_rdata_o;
    bus_write(8'hA0, 32'h1234_5678);
    @(negedge clk);
    check(bus_rdata_o == keep, "R9 hold across idle and write", 64'(bus_rdata_o), 64'(keep));

    // Random mix over all slots and both halves
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int unsigned k;
      pend_i = {$urandom(), $urandom()};
      k = $urandom % 16;
      if (k < 13) a = 8'h80 + 8'(k * 8) + 8'(($urandom % 2) * 4);
      else if (k == 13) a = 8'(($urandom % 32) * 4);
      else a = 8'hE8 + 8'(($urandom % 6) * 4);
      d = $urandom();
      if ($urandom % 2 == 1) bus_write(a, d);
      else bus_read(a, "R2 random read vs model");
      #1;
      check_lines("R5 random lines");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule